// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers 96 peripheral interrupt requests into 12 CPU interrupt lines. The sources form fixed groups of eight: source `i` belongs to group `i / 8` and sits at position `i % 8` within it. Each source has three pieces of state: a pending flag, an enable bit and a software-writable vector word. A group's CPU line is raised when any source in the group is both pending and enabled, unless that group is blocked.

When the CPU acknowledges a line, the block picks a winner in that group. The winner is the pending, enabled source with the lowest position. The block captures that source's vector and clears its flag. It also sets a block bit for the group, which holds the line low until software clears it. The vector is presented after a fixed latency that covers the fetch and the context save. If nothing in the group qualifies, a fixed fallback vector is returned instead. A single write port loads vectors, loads group enable masks, and clears group block bits.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset, every CPU line is low, `vec_valid` is low, all flags, enables and block bits are zero, and every vector entry is zero.
- R2: A request bit that is high on any clock edge sets that source's flag. The flag stays set after the request drops, until the source's vector is delivered.
- R3: A pending source whose enable bit is 0 does not raise its line. Setting the enable later raises the line, using the flag that was already held.
- R4: Source `i` drives only line `i/8`. Line `g` is high exactly when some source in group `g` is pending and enabled and the group's block bit is clear.
- R5: On an acknowledge, the winner is the pending, enabled source with the lowest position in the group, and its vector entry is delivered.
- R6: An acknowledge is accepted on a clock edge where `ack_valid` is high and no fetch is in progress. `vec_valid` pulses for exactly one cycle, starting LAT-1 clock edges after the accepting edge, with LAT = 8 by default. `vec_valid` is low in all the cycles before that.
- R7: Delivery clears only the winner's flag. Other pending sources of the group stay pending.
- R8: An accepted acknowledge sets the group's block bit, and the group's line is low from the next cycle on. A write with `wr_kind` = 2 clears the block bit of each group `g` whose `wr_data[g]` is 1. Bits that are 0 leave their groups unchanged.
- R9: When an acknowledged group has no pending, enabled source, `vec_out` carries DEF_VEC (default 16'hFFFF) and no flag changes.
- R10: An `ack_valid` that arrives while a fetch is in progress is ignored. No flag, block bit or line of the requested group changes because of it.
- R11: A write with `wr_kind` = 0 stores `wr_data` as the vector of source `wr_addr`. A write with `wr_kind` = 1 loads group `wr_addr`'s enables: `wr_data[b]` is the enable of source `wr_addr*8+b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 96 | Peripheral request bits, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 vector, 1 group enable mask, 2 block-bit clear |
| wr_addr | input | 7 | Source index (kind 0) or group index (kind 1) |
| wr_data | input | 16 | Vector word, enable mask or clear mask |
| cpu_int | output | 12 | CPU interrupt lines, one per group |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_grp | input | 4 | Group being acknowledged |
| vec_valid | output | 1 | One-cycle strobe marking the delivered vector |
| vec_out | output | 16 | Delivered vector |

## Verification
Some behaviours are checked by assertions on every cycle. A group's line drops right after its acknowledge is accepted. A fetch never produces its vector in the cycle after acceptance. The vector strobe lasts a single cycle. The block bits hold still during a fetch unless software clears them.

Other behaviours can only be shown by the bench's scenarios, which compare the block against an independent model. These are the priority choice among several pending sources and the exact eight-cycle timing. They also include the survival of losing flags, the fallback vector for an empty group, and the effect of enables and vector writes. The bench's random mix of writes, pulses, acknowledges and clears checks the line mapping across all twelve groups.

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int NGRP    = 12,
  parameter int GSZ     = 8,
  parameter int VW      = 16,
  parameter int LAT     = 8,
  parameter int DEF_VEC = 'hFFFF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NGRP*GSZ-1:0]             irq_in,
  input  logic                            wr_en,
  input  logic [1:0]                      wr_kind,
  input  logic [$clog2(NGRP*GSZ)-1:0]     wr_addr,
  input  logic [VW-1:0]                   wr_data,
  output logic [NGRP-1:0]                 cpu_int,
  input  logic                            ack_valid,
  input  logic [$clog2(NGRP)-1:0]         ack_grp,
  output logic                            vec_valid,
  output logic [VW-1:0]                   vec_out
);
  localparam int NSRC = NGRP * GSZ;
  localparam int AW   = $clog2(NSRC);
  localparam int BW   = $clog2(GSZ);
  localparam int CW   = $clog2(LAT);

  logic [NSRC-1:0] flag, en, pend, clr;
  logic [NGRP-1:0] gack, gset;
  logic [VW-1:0]   vtab [NSRC];
  logic [VW-1:0]   vec_q;
  logic [CW-1:0]   cnt;
  logic            busy, accept, hit;
  logic [GSZ-1:0]  gbits;
  logic [BW-1:0]   widx;
  logic [AW-1:0]   src;

  assign pend   = flag & en;
  assign accept = ack_valid && !busy && (int'(ack_grp) < NGRP);
  assign gbits  = pend[int'(ack_grp)*GSZ +: GSZ];

  always_comb begin
    hit  = 1'b0;
    widx = '0;
    for (int b = GSZ-1; b >= 0; b--)
      if (gbits[b]) begin
        hit  = 1'b1;
        widx = BW'(b);
      end
  end

  assign src  = AW'(int'(ack_grp)*GSZ + int'(widx));
  assign clr  = (accept && hit) ? (NSRC'(1) << src) : '0;
  assign gset = accept ? (NGRP'(1) << ack_grp) : '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_line
    assign cpu_int[g] = (|pend[g*GSZ +: GSZ]) && !gack[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
      gack <= '0;
      for (int i = 0; i < NSRC; i++) vtab[i] <= '0;
    end else begin
      flag <= (flag & ~clr) | irq_in;
      if (wr_en && wr_kind == 2'd2) gack <= (gack & ~wr_data[NGRP-1:0]) | gset;
      else                          gack <= gack | gset;
      if (wr_en && wr_kind == 2'd1 && int'(wr_addr) < NGRP)
        en[int'(wr_addr)*GSZ +: GSZ] <= wr_data[GSZ-1:0];
      if (wr_en && wr_kind == 2'd0 && int'(wr_addr) < NSRC)
        vtab[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      vec_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      vec_q <= hit ? vtab[src] : VW'(DEF_VEC);
    end else if (busy) begin
      if (int'(cnt) == LAT-1) busy <= 1'b0;
      else                    cnt  <= cnt + 1'b1;
    end
  end

  assign vec_valid = busy && (int'(cnt) == LAT-1);
  assign vec_out   = vec_q;

  p_line_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cpu_int[$past(ack_grp)]);
  p_no_early_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !vec_valid);
  p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && wr_kind == 2'd2)) |=> $stable(gack));
endmodule

// File: tb/tb_grp_irq_expander.sv
`timescale 1ns/1ps
module tb_grp_irq_expander;
  localparam int NG = 12, GS = 8, NS = 96;
  logic clk = 0, rst_n = 0;
  logic [NS-1:0] irq_in = '0;
  logic wr_en = 0; logic [1:0] wr_kind = 0; logic [6:0] wr_addr = 0; logic [15:0] wr_data = 0;
  logic ack_valid = 0; logic [3:0] ack_grp = 0;
  logic [NG-1:0] cpu_int; logic vec_valid; logic [15:0] vec_out;

  grp_irq_expander dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_addr(wr_addr), .wr_data(wr_data), .cpu_int(cpu_int), .ack_valid(ack_valid),
    .ack_grp(ack_grp), .vec_valid(vec_valid), .vec_out(vec_out));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_flag [NS]; bit m_en [NS]; logic [15:0] m_vec [NS]; bit m_gack [NG];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic logic [NG-1:0] exp_lines();
    logic [NG-1:0] r = '0;
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < GS; b++)
        if (m_flag[g*GS+b] && m_en[g*GS+b] && !m_gack[g]) r[g] = 1'b1;
    return r;
  endfunction

  function automatic int winner(input int g);
    for (int b = 0; b < GS; b++) if (m_flag[g*GS+b] && m_en[g*GS+b]) return g*GS+b;
    return -1;
  endfunction

  task automatic wr(input int kind, input int addr, input logic [15:0] data);
    wr_en = 1; wr_kind = 2'(kind); wr_addr = 7'(addr); wr_data = data;
    @(negedge clk); wr_en = 0;
    if (kind == 0) m_vec[addr] = data;
    else if (kind == 1) for (int b = 0; b < GS; b++) m_en[addr*GS+b] = data[b];
    else for (int g = 0; g < NG; g++) if (data[g]) m_gack[g] = 0;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    irq_in = m; @(negedge clk); irq_in = '0;
    for (int i = 0; i < NS; i++) if (m[i]) m_flag[i] = 1;
  endtask

  task automatic do_ack(input int g, input string req);
    int w = winner(g);
    logic [15:0] ev = (w < 0) ? 16'hFFFF : m_vec[w];
    if (w >= 0) m_flag[w] = 0;
    m_gack[g] = 1;
    ack_valid = 1; ack_grp = 4'(g);
    @(negedge clk); ack_valid = 0;
    repeat (6) @(negedge clk);
    chk(vec_valid == 0, "R6 early", 32'(vec_valid), 0);
    @(negedge clk);
    chk(vec_valid == 1, "R6 strobe", 32'(vec_valid), 1);
    chk(vec_out == ev, req, 32'(vec_out), 32'(ev));
    @(negedge clk);
    chk(vec_valid == 0, "R6 one cycle", 32'(vec_valid), 0);
  endtask

  task automatic chk_lines(input string req);
    logic [NG-1:0] e = exp_lines();
    chk(cpu_int == e, req, 32'(cpu_int), 32'(e));
  endtask

  initial begin
    #(200000 * 8);
    errors++; $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] m;
    void'($urandom(32'd20250611));
    for (int i = 0; i < NS; i++) begin m_flag[i] = 0; m_en[i] = 0; m_vec[i] = 0; end
    for (int g = 0; g < NG; g++) m_gack[g] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk(cpu_int == 0 && vec_valid == 0, "R1 reset", {cpu_int, 3'b0, vec_valid}, 0);
    do_ack(0, "R1 reset vector/R9 default");
    wr(2, 0, 16'hFFFF);

    for (int i = 0; i < NS; i++) wr(0, i, 16'($urandom));
    pulse(NS'(1) << 5);
    chk_lines("R3 disabled pending");
    chk(cpu_int[0] == 0, "R3 disabled line", 32'(cpu_int), 0);
    wr(1, 0, 16'h00FF);
    chk(cpu_int[0] == 1, "R3/R2 held flag", 32'(cpu_int), 1);

    for (int g = 1; g < NG; g++) wr(1, g, 16'h00FF);
    pulse(NS'(1) << (7*GS + 4));
    chk(cpu_int == 12'h081, "R4 mapping", 32'(cpu_int), 32'h081);

    pulse((NS'(1) << 30) | (NS'(1) << 26));
    do_ack(3, "R5 lowest wins");
    chk(cpu_int[3] == 0, "R8 blocked", 32'(cpu_int), 0);
    wr(2, 0, 16'h0001);
    chk(cpu_int[3] == 0, "R8 other bit no effect", 32'(cpu_int), 0);
    wr(2, 0, 16'h0008);
    chk(cpu_int[3] == 1, "R7 loser kept/R8 cleared", 32'(cpu_int), 1);
    do_ack(3, "R7 second source");
    wr(2, 0, 16'h0008);
    chk(cpu_int[3] == 0, "R7 group drained", 32'(cpu_int), 0);
    do_ack(3, "R9 default vector");
    wr(2, 0, 16'h0008);
    chk_lines("R9 no flag change");

    wr(0, 5, 16'h1234);
    do_ack(0, "R11 rewritten vector");
    wr(2, 0, 16'h0001);

    pulse(NS'(1) << (9*GS + 1));
    ack_valid = 1; ack_grp = 4'd7;
    @(negedge clk); ack_valid = 0; m_flag[7*GS+4] = 0; m_gack[7] = 1;
    @(negedge clk);
    ack_valid = 1; ack_grp = 4'd9;
    @(negedge clk); ack_valid = 0;
    repeat (8) @(negedge clk);
    chk(cpu_int[9] == 1, "R10 ignored ack", 32'(cpu_int), 1);
    chk_lines("R10 lines");
    wr(2, 0, 16'h0080);

    for (int it = 0; it < 300; it++) begin
      case ($urandom % 5)
        0: wr(0, $urandom % NS, 16'($urandom));
        1: wr(1, $urandom % NG, 16'($urandom % 256));
        2: begin
          m = '0;
          for (int i = 0; i < NS; i++) if ($urandom % 16 == 0) m[i] = 1;
          pulse(m);
        end
        3: if (m_gack[0] == 0 || 1) begin
          int g = $urandom % NG;
          if (!m_gack[g]) do_ack(g, "R5 random ack");
        end
        default: wr(2, 0, 16'($urandom % 4096));
      endcase
      chk_lines("R4 random lines");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule